// File: doc/BRIEF.md
# Serial flash command front end

This block is the slave-side instruction interface of a serial NOR flash device. A host selects the device with an active-low chip select, clocks an 8-bit opcode in on lane 0, and the block then decides how the rest of the selection proceeds. It may capture a 24-bit address on one, two or four lanes. It may skip mode and dummy clocks. Finally it streams bytes back on one, two or four lanes. Those bytes come either from an external byte-read port into the memory array or from fixed identification values. Opcodes that are unknown, or that need quad lanes while quad operation is disabled, leave the device silent until chip select rises again.

The block runs on a system clock that is several times faster than the serial clock. It passes the serial clock, chip select and the four input lanes through one common synchronizer, and it finds the serial clock edges in the system-clock domain. It samples input bits on serial-clock rising edges and changes output bits on falling edges. Because of this, bus modes 0 and 3 both work. The array port is combinational: the block presents `mem_addr`, samples `mem_rdata` in the cycle where `mem_rd` is high, and advances the address one cycle later. Each serial-clock half period must last at least `SYNC_STAGES + 3` system clocks.

Top module: `spi_flash_cmd_fe`

## Requirements
- R1: While `rst_n` is low, and in the cycles right after it is asserted, `lane_oe` is 0000 and `mem_rd` is low. After reset the device answers nothing until it is selected again.
- R2: A selection begins only on a high-to-low transition of `cs_n` that is seen after reset is released. If `cs_n` is held low through reset, serial clocks that follow drive no lane.
- R3: Opcode 9Fh returns the bytes E0h, 40h, 14h on lane 1, MSB first, with `lane_oe` = 0010. The three bytes repeat in that order for as long as clocking continues.
- R4: Opcode 90h is followed by three bytes that are ignored. It then returns E0h, 13h, repeating. Opcode ABh is followed by three ignored bytes and then returns 13h repeatedly. Both use lane 1 only.
- R5: Opcode 0Bh takes a 24-bit address on lane 0, MSB first. It then skips 8 dummy clocks and returns array bytes on lane 1, starting at that address and moving up one address per byte.
- R6: Opcode 3Bh takes the address on lane 0 and skips 8 dummy clocks. It then returns array bytes on lanes 1:0 with `lane_oe` = 0011, four clocks per byte, lane 1 carrying the more significant bit of each pair.
- R7: Opcode BBh takes the address on lanes 1:0 in 12 clocks, lane 1 first-significant. Four mode clocks follow and their content is ignored. Data is then returned on two lanes as in R6.
- R8: With `quad_en` = 1, opcode 6Bh takes the address on lane 0 and skips 8 dummy clocks. It then returns data on lanes 3:0 with `lane_oe` = 1111, two clocks per byte, lane 3 carrying the MSB of each nibble.
- R9: With `quad_en` = 1, opcode EBh takes the address on lanes 3:0 in 6 clocks, nibble-wise MSB first. A 2-clock mode byte (ignored) and 4 dummy clocks follow, then quad data as in R8.
- R10: With `quad_en` = 0, opcodes 6Bh and EBh are ignored. For the rest of that selection no lane is driven and `mem_rd` stays low.
- R11: When `cs_n` rises, all lanes are tri-stated at once, whatever the phase. The next selection decodes a fresh opcode and restarts any identification sequence from its first byte.
- R12: Bus mode 0 (serial clock idle low) and mode 3 (idle high) give the same results.
- R13: An opcode outside the set above is ignored in the same way as R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial bus |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| quad_en | input | 1 | Configuration bit that permits the four-lane opcodes |
| sclk | input | 1 | Serial bus clock |
| cs_n | input | 1 | Active-low chip select |
| lane_in | input | 4 | Values seen on the four data lanes |
| lane_out | output | 4 | Values driven onto the data lanes |
| lane_oe | output | 4 | Per-lane output enable |
| mem_addr | output | ADDR_W | Byte address presented to the array |
| mem_rd | output | 1 | High in the cycle where `mem_rdata` is taken |
| mem_rdata | input | 8 | Array byte at `mem_addr` |

## Verification
Every read opcode is driven against an array model that returns a distinct value for each address. A mismatch therefore separates a wrong start address, a missing increment, a lane order swapped inside a byte and a wrong dummy count from one another. The identification opcodes are read for longer than their sequence, so wrong byte order and wrong wrap length both show up. The same transfers are repeated in mode 3, during quad disable, after unknown opcodes, after chip select rises mid-address or mid-data, and with chip select held low across reset. These runs tell correct gating and restarting apart from leftover state.

// File: rtl/sfc_pkg.sv
// Shared types and constants for the serial flash command front end.
// Assumes 8-bit opcodes and identification bytes sent MSB first.
package sfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_PAD,
        ST_DATA,
        ST_IGNORE
    } sfc_state_e;

    typedef enum logic [1:0] {
        ID_NONE,
        ID_JEDEC,
        ID_MFR_DEV,
        ID_DEV
    } id_sel_e;

    // How one opcode proceeds after its 8 clocks.
    typedef struct packed {
        logic       valid;
        logic       needs_quad;
        logic       has_addr;
        logic [2:0] addr_w;    // lanes used for address: 1, 2 or 4
        logic [3:0] pad_clks;  // mode plus dummy clocks after the address
        logic [2:0] data_w;    // lanes used for output: 1, 2 or 4
        id_sel_e    id_sel;    // ID_NONE means data comes from the array
    } cmd_desc_t;

    localparam logic [7:0] OPC_FAST     = 8'h0B;
    localparam logic [7:0] OPC_DUAL_OUT = 8'h3B;
    localparam logic [7:0] OPC_DUAL_IO  = 8'hBB;
    localparam logic [7:0] OPC_QUAD_OUT = 8'h6B;
    localparam logic [7:0] OPC_QUAD_IO  = 8'hEB;
    localparam logic [7:0] OPC_JEDEC    = 8'h9F;
    localparam logic [7:0] OPC_MFR_DEV  = 8'h90;
    localparam logic [7:0] OPC_DEV      = 8'hAB;

    // Byte at position idx of an identification sequence.
    function automatic logic [7:0] id_byte(input id_sel_e sel, input logic [1:0] idx);
        logic [7:0] b;
        case (sel)
            ID_JEDEC:   b = (idx == 2'd0) ? 8'hE0 : (idx == 2'd1) ? 8'h40 : 8'h14;
            ID_MFR_DEV: b = (idx == 2'd0) ? 8'hE0 : 8'h13;
            ID_DEV:     b = 8'h13;
            default:    b = 8'h00;
        endcase
        return b;
    endfunction

    // Length of an identification sequence before it wraps.
    function automatic logic [1:0] id_len(input id_sel_e sel);
        logic [1:0] n;
        case (sel)
            ID_JEDEC:   n = 2'd3;
            ID_MFR_DEV: n = 2'd2;
            default:    n = 2'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sfc_bus_sync.sv
// Multi-stage synchronizer for the raw serial bus signals.
// Assumes every bit gets the same delay so that lanes stay aligned with sclk.
// All stages reset to zero: chip select seen as low until a real high arrives.
module sfc_bus_sync #(
    parameter int STAGES = 2,
    parameter int W      = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);

    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the bus one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/sfc_cmd_decode.sv
// Opcode decoder: maps an 8-bit opcode to its phase descriptor.
// Purely combinational; quad gating is left to the caller.
module sfc_cmd_decode
    import sfc_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_desc_t  desc
);

    // Look up the phase plan for the opcode.
    always_comb begin
        desc = '0;
        case (opcode)
            OPC_FAST:     desc = '{valid: 1'b1, needs_quad: 1'b0, has_addr: 1'b1, addr_w: 3'd1,
                                   pad_clks: 4'd8, data_w: 3'd1, id_sel: ID_NONE};
            OPC_DUAL_OUT: desc = '{valid: 1'b1, needs_quad: 1'b0, has_addr: 1'b1, addr_w: 3'd1,
                                   pad_clks: 4'd8, data_w: 3'd2, id_sel: ID_NONE};
            OPC_DUAL_IO:  desc = '{valid: 1'b1, needs_quad: 1'b0, has_addr: 1'b1, addr_w: 3'd2,
                                   pad_clks: 4'd4, data_w: 3'd2, id_sel: ID_NONE};
            OPC_QUAD_OUT: desc = '{valid: 1'b1, needs_quad: 1'b1, has_addr: 1'b1, addr_w: 3'd1,
                                   pad_clks: 4'd8, data_w: 3'd4, id_sel: ID_NONE};
            OPC_QUAD_IO:  desc = '{valid: 1'b1, needs_quad: 1'b1, has_addr: 1'b1, addr_w: 3'd4,
                                   pad_clks: 4'd6, data_w: 3'd4, id_sel: ID_NONE};
            OPC_JEDEC:    desc = '{valid: 1'b1, needs_quad: 1'b0, has_addr: 1'b0, addr_w: 3'd1,
                                   pad_clks: 4'd0, data_w: 3'd1, id_sel: ID_JEDEC};
            OPC_MFR_DEV:  desc = '{valid: 1'b1, needs_quad: 1'b0, has_addr: 1'b1, addr_w: 3'd1,
                                   pad_clks: 4'd0, data_w: 3'd1, id_sel: ID_MFR_DEV};
            OPC_DEV:      desc = '{valid: 1'b1, needs_quad: 1'b0, has_addr: 1'b1, addr_w: 3'd1,
                                   pad_clks: 4'd0, data_w: 3'd1, id_sel: ID_DEV};
            default:      desc = '0;
        endcase
    end

endmodule

// File: rtl/sfc_out_shift.sv
// Output byte shifter for one, two or four lanes.
// A load latches a byte and its lane width; each shift moves it by that width.
// Single-lane data leaves on lane 1; wider modes use lanes from 0 upward, MSB on the top lane.
module sfc_out_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load,
    input  logic       shift,
    input  logic [7:0] byte_in,
    input  logic [2:0] width,
    output logic [3:0] lane_out,
    output logic [3:0] lane_oe
);

    logic [7:0] sh_q;
    logic [2:0] w_q;
    logic       drv_q;

    // Hold, load or advance the outgoing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            w_q   <= 3'd1;
            drv_q <= 1'b0;
        end else if (clear) begin
            drv_q <= 1'b0;
        end else if (load) begin
            sh_q  <= byte_in;
            w_q   <= width;
            drv_q <= 1'b1;
        end else if (shift) begin
            sh_q  <= sh_q << w_q;
        end
    end

    // Place the leading bits on the lanes and enable the lanes in use.
    always_comb begin
        case (w_q)
            3'd4: begin
                lane_out = sh_q[7:4];
                lane_oe  = drv_q ? 4'b1111 : 4'b0000;
            end
            3'd2: begin
                lane_out = {2'b00, sh_q[7:6]};
                lane_oe  = drv_q ? 4'b0011 : 4'b0000;
            end
            default: begin
                lane_out = {2'b00, sh_q[7], 1'b0};
                lane_oe  = drv_q ? 4'b0010 : 4'b0000;
            end
        endcase
    end

endmodule

// File: rtl/spi_flash_cmd_fe.sv
// Serial flash command front end (top).
// Oversamples sclk, cs_n and the lanes with clk, captures an opcode and steps
// through address, pad and data phases as the decoded descriptor dictates.
// Assumes each sclk half period lasts at least SYNC_STAGES + 3 clk cycles and
// that mem_rdata follows mem_addr combinationally.
module spi_flash_cmd_fe
    import sfc_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quad_en,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic [3:0]        lane_in,
    output logic [3:0]        lane_out,
    output logic [3:0]        lane_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata
);

    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] LAST_A1 = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_A2 = CNT_W'(ADDR_W / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_A4 = CNT_W'(ADDR_W / 4 - 1);
    localparam logic [CNT_W-1:0] LAST_OP = CNT_W'(7);

    logic [5:0]        sync_bus;
    logic              s_sclk, s_cs;
    logic [3:0]        s_lane;
    logic              sclk_q, cs_q;
    logic              sclk_rise, sclk_fall, cs_fall;

    sfc_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [6:0]        opc_q;
    logic [7:0]        opc_next;
    logic [ADDR_W-1:0] addr_q, addr_next, mem_addr_q;
    cmd_desc_t         desc_q, dec;
    logic [2:0]        out_cnt_q, out_reload;
    logic [1:0]        id_idx_q;

    int                a_shift;
    logic [3:0]        a_mask;
    logic [CNT_W-1:0]  a_last;
    logic              in_data, load, shift_en;
    logic [7:0]        byte_src;
    logic [3:0]        sh_oe;

    sfc_bus_sync #(.STAGES(SYNC_STAGES), .W(6)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   ({lane_in, cs_n, sclk}),
        .d_sync (sync_bus)
    );

    assign s_sclk = sync_bus[0];
    assign s_cs   = sync_bus[1];
    assign s_lane = sync_bus[5:2];

    // Remember the previous synchronized sclk and cs_n for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            sclk_q <= s_sclk;
            cs_q   <= s_cs;
        end
    end

    assign sclk_rise = s_sclk & ~sclk_q;
    assign sclk_fall = ~s_sclk & sclk_q;
    assign cs_fall   = ~s_cs & cs_q;
    assign opc_next  = {opc_q, s_lane[0]};

    sfc_cmd_decode u_dec (
        .opcode (opc_next),
        .desc   (dec)
    );

    // Per-phase address shift amount, lane mask and final count.
    always_comb begin
        case (desc_q.addr_w)
            3'd4:    begin a_shift = 4; a_mask = 4'b1111; a_last = LAST_A4; end
            3'd2:    begin a_shift = 2; a_mask = 4'b0011; a_last = LAST_A2; end
            default: begin a_shift = 1; a_mask = 4'b0001; a_last = LAST_A1; end
        endcase
        case (desc_q.data_w)
            3'd4:    out_reload = 3'd1;
            3'd2:    out_reload = 3'd3;
            default: out_reload = 3'd7;
        endcase
    end

    assign addr_next = (addr_q << a_shift) | {{(ADDR_W-4){1'b0}}, s_lane & a_mask};
    assign byte_src  = (desc_q.id_sel == ID_NONE) ? mem_rdata : id_byte(desc_q.id_sel, id_idx_q);
    assign in_data   = (state_q == ST_DATA) && !s_cs && sclk_fall;
    assign load      = in_data && (out_cnt_q == 3'd0);
    assign shift_en  = in_data && (out_cnt_q != 3'd0);
    assign mem_rd    = load && (desc_q.id_sel == ID_NONE);
    assign mem_addr  = mem_addr_q;

    // Instruction sequencer: opcode, address, pad and data phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            opc_q      <= '0;
            addr_q     <= '0;
            desc_q     <= '0;
            out_cnt_q  <= '0;
            id_idx_q   <= '0;
            mem_addr_q <= '0;
        end else if (s_cs) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            out_cnt_q <= '0;
            id_idx_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cs_fall) begin
                        state_q <= ST_OPC;
                        cnt_q   <= '0;
                    end
                end
                ST_OPC: begin
                    if (sclk_rise) begin
                        opc_q <= opc_next[6:0];
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST_OP) begin
                            cnt_q  <= '0;
                            desc_q <= dec;
                            if (!dec.valid || (dec.needs_quad && !quad_en))
                                state_q <= ST_IGNORE;
                            else if (dec.has_addr)
                                state_q <= ST_ADDR;
                            else if (dec.pad_clks != 4'd0)
                                state_q <= ST_PAD;
                            else
                                state_q <= ST_DATA;
                        end
                    end
                end
                ST_ADDR: begin
                    if (sclk_rise) begin
                        addr_q <= addr_next;
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == a_last) begin
                            cnt_q      <= '0;
                            mem_addr_q <= addr_next;
                            state_q    <= (desc_q.pad_clks != 4'd0) ? ST_PAD : ST_DATA;
                        end
                    end
                end
                ST_PAD: begin
                    if (sclk_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(desc_q.pad_clks - 4'd1)) begin
                            cnt_q   <= '0;
                            state_q <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (load) begin
                        out_cnt_q <= out_reload;
                        if (desc_q.id_sel == ID_NONE)
                            mem_addr_q <= mem_addr_q + 1'b1;
                        else
                            id_idx_q <= (id_idx_q == id_len(desc_q.id_sel) - 2'd1) ? 2'd0 : id_idx_q + 2'd1;
                    end else if (shift_en) begin
                        out_cnt_q <= out_cnt_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    sfc_out_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (s_cs),
        .load     (load),
        .shift    (shift_en),
        .byte_in  (byte_src),
        .width    (desc_q.data_w),
        .lane_out (lane_out),
        .lane_oe  (sh_oe)
    );

    assign lane_oe = sh_oe & {4{~cs_n}};

    AST_OE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_oe != 4'b0000) |-> (state_q == ST_DATA)); // R11
    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs |=> (state_q == ST_IDLE && sh_oe == 4'b0000)); // R11
    AST_QUAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPC && sclk_rise && !s_cs && cnt_q == LAST_OP && dec.needs_quad && !quad_en)
        |=> (state_q == ST_IGNORE)); // R10
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> (sh_oe == 4'b0000 && !mem_rd)); // R13
    AST_ID_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && desc_q.id_sel != ID_NONE) |-> (sh_oe == 4'b0000 || sh_oe == 4'b0010)); // R3

endmodule

// File: tb/spi_flash_cmd_fe_bench.sv
// Scoreboard bench: host tasks push expected bytes, a monitor compares received ones.
module spi_flash_cmd_fe_bench;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        quad_en;
    logic        sclk;
    logic        cs_n;
    logic [3:0]  lane_in;
    logic [3:0]  lane_out;
    logic [3:0]  lane_oe;
    logic [23:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;

    int n_run  = 0;
    int n_fail = 0;
    int oe_cnt = 0;
    int rd_cnt = 0;

    typedef struct {
        logic [7:0] val;
        logic [3:0] oe;
        string      req;
    } exp_t;

    typedef struct {
        logic [7:0] val;
        logic [3:0] oe;
    } rx_t;

    exp_t exp_q[$];
    rx_t  rx_q[$];

    always #5 clk = ~clk;

    spi_flash_cmd_fe u_spi_flash_cmd_fe (
        .clk       (clk),
        .rst_n     (rst_n),
        .quad_en   (quad_en),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .lane_in   (lane_in),
        .lane_out  (lane_out),
        .lane_oe   (lane_oe),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] mem_fn(input logic [23:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    assign mem_rdata = mem_fn(mem_addr);

    always @(posedge clk) begin
        if (lane_oe != 4'b0000) oe_cnt <= oe_cnt + 1;
        if (mem_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input logic [3:0] oe, input string req);
        exp_t e;
        e.val = v;
        e.oe  = oe;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // One serial clock: low half with data driven, sample at the rising edge.
    task automatic sclk_cycle(input logic [3:0] d, output logic [3:0] s, output logic [3:0] o);
        sclk    = 1'b0;
        lane_in = d;
        repeat (H) @(negedge clk);
        sclk = 1'b1;
        s    = lane_out;
        o    = lane_oe;
        repeat (H) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int w);
        logic [3:0] s, o;
        logic [7:0] r = b;
        for (int k = 0; k < 8 / w; k++) begin
            case (w)
                4:       sclk_cycle(r[7:4], s, o);
                2:       sclk_cycle({2'b00, r[7:6]}, s, o);
                default: sclk_cycle({3'b000, r[7]}, s, o);
            endcase
            r = r << w;
        end
    endtask

    task automatic send_addr(input logic [23:0] a, input int w);
        send_byte(a[23:16], w);
        send_byte(a[15:8], w);
        send_byte(a[7:0], w);
    endtask

    task automatic pad(input int n);
        logic [3:0] s, o;
        for (int k = 0; k < n; k++) sclk_cycle(4'b0000, s, o);
    endtask

    task automatic recv_bytes(input int w, input int n);
        logic [3:0] s, o;
        rx_t r;
        for (int j = 0; j < n; j++) begin
            r.val = '0;
            r.oe  = '0;
            for (int k = 0; k < 8 / w; k++) begin
                sclk_cycle(4'b0000, s, o);
                if (k == 0) r.oe = o;
                else if (o != r.oe) r.oe = 4'b1010;
                case (w)
                    4:       r.val = {r.val[3:0], s};
                    2:       r.val = {r.val[5:0], s[1:0]};
                    default: r.val = {r.val[6:0], s[1]};
                endcase
            end
            rx_q.push_back(r);
        end
    endtask

    task automatic select(input bit mode3);
        sclk = mode3;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic deselect(input bit mode3);
        if (!mode3) sclk = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic read_mem(input logic [7:0] opc, input logic [23:0] a, input int aw,
                            input int dw, input logic [3:0] oe, input string req, input bit mode3);
        select(mode3);
        send_byte(opc, 1);
        send_addr(a, aw);
        case (opc)
            8'hBB:   send_byte(8'hA5, 2);
            8'hEB:   begin send_byte(8'hA5, 4); pad(4); end
            default: pad(8);
        endcase
        for (int j = 0; j < 3; j++) expect_byte(mem_fn(a + 24'(j)), oe, req);
        recv_bytes(dw, 3);
        deselect(mode3);
    endtask

    task automatic silent_cmd(input logic [7:0] opc, input string req);
        int oe0, rd0;
        select(1'b0);
        oe0 = oe_cnt;
        rd0 = rd_cnt;
        send_byte(opc, 1);
        send_addr(24'h000100, 4);
        pad(30);
        chk(oe_cnt == oe0, req, "lanes driven while ignored", oe_cnt - oe0, 0);
        chk(rd_cnt == rd0, req, "array read while ignored", rd_cnt - rd0, 0);
        deselect(1'b0);
    endtask

    // Monitor: pair each received byte with the next expected item.
    initial begin
        rx_t  r;
        exp_t e;
        forever begin
            wait (rx_q.size() != 0);
            r = rx_q.pop_front();
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected byte", r.val, 0);
            end else begin
                e = exp_q.pop_front();
                chk(r.val == e.val, e.req, "data byte", r.val, e.val);
                chk(r.oe == e.oe, e.req, "lane enables", r.oe, e.oe);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL R11 watchdog expired: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int oe0;
        rst_n   = 1'b0;
        quad_en = 1'b0;
        sclk    = 1'b0;
        cs_n    = 1'b0;
        lane_in = 4'b0000;
        repeat (6) @(negedge clk);
        chk(lane_oe == 4'b0000, "R1", "oe in reset", lane_oe, 0);
        chk(mem_rd == 1'b0, "R1", "mem_rd in reset", mem_rd, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R2: chip select low through reset starts nothing.
        oe0 = oe_cnt;
        send_byte(8'h9F, 1);
        pad(16);
        chk(oe_cnt == oe0, "R2", "driven without cs falling edge", oe_cnt - oe0, 0);
        deselect(1'b0);

        // R3: JEDEC sequence wraps after three bytes.
        select(1'b0);
        send_byte(8'h9F, 1);
        expect_byte(8'hE0, 4'b0010, "R3");
        expect_byte(8'h40, 4'b0010, "R3");
        expect_byte(8'h14, 4'b0010, "R3");
        expect_byte(8'hE0, 4'b0010, "R3");
        recv_bytes(1, 4);
        deselect(1'b0);

        // R12: same in mode 3.
        select(1'b1);
        send_byte(8'h9F, 1);
        expect_byte(8'hE0, 4'b0010, "R12");
        expect_byte(8'h40, 4'b0010, "R12");
        recv_bytes(1, 2);
        deselect(1'b1);

        // R4: manufacturer/device and device-only identification.
        select(1'b0);
        send_byte(8'h90, 1);
        send_addr(24'h000000, 1);
        expect_byte(8'hE0, 4'b0010, "R4");
        expect_byte(8'h13, 4'b0010, "R4");
        expect_byte(8'hE0, 4'b0010, "R4");
        recv_bytes(1, 3);
        deselect(1'b0);
        select(1'b0);
        send_byte(8'hAB, 1);
        send_addr(24'hFFFFFF, 1);
        expect_byte(8'h13, 4'b0010, "R4");
        expect_byte(8'h13, 4'b0010, "R4");
        recv_bytes(1, 2);
        deselect(1'b0);

        // R5, R6, R7: single and dual reads; R12 repeats one in mode 3.
        read_mem(8'h0B, 24'h001234, 1, 1, 4'b0010, "R5", 1'b0);
        read_mem(8'h0B, 24'h0300FE, 1, 1, 4'b0010, "R12", 1'b1);
        read_mem(8'h3B, 24'h0ABCDE, 1, 2, 4'b0011, "R6", 1'b0);
        read_mem(8'hBB, 24'h05A5C3, 2, 2, 4'b0011, "R7", 1'b0);

        // R10, R13: gated and unknown opcodes stay silent.
        silent_cmd(8'h6B, "R10");
        silent_cmd(8'hEB, "R10");
        silent_cmd(8'h55, "R13");

        // R8, R9: quad reads with quad enabled.
        quad_en = 1'b1;
        read_mem(8'h6B, 24'h0F0F11, 1, 4, 4'b1111, "R8", 1'b0);
        read_mem(8'hEB, 24'h0123AF, 4, 4, 4'b1111, "R9", 1'b0);
        read_mem(8'hEB, 24'h0777F0, 4, 4, 4'b1111, "R12", 1'b1);

        // R11: abort mid-data, lanes released at once, ID restarts.
        select(1'b0);
        send_byte(8'h9F, 1);
        expect_byte(8'hE0, 4'b0010, "R11");
        recv_bytes(1, 1);
        pad(3);
        cs_n = 1'b1;
        @(negedge clk);
        chk(lane_oe == 4'b0000, "R11", "oe after cs rise", lane_oe, 0);
        repeat (12) @(negedge clk);
        select(1'b0);
        send_byte(8'h9F, 1);
        expect_byte(8'hE0, 4'b0010, "R11");
        expect_byte(8'h40, 4'b0010, "R11");
        recv_bytes(1, 2);
        deselect(1'b0);

        // R11: abort mid-address, next opcode is decoded fresh.
        select(1'b0);
        send_byte(8'h0B, 1);
        send_byte(8'h12, 1);
        send_byte(8'h34, 1);
        deselect(1'b0);
        select(1'b0);
        send_byte(8'hAB, 1);
        send_addr(24'h000000, 1);
        expect_byte(8'h13, 4'b0010, "R11");
        recv_bytes(1, 1);
        deselect(1'b0);

        // R1, R2: reset during a transfer, then cs held low after reset.
        select(1'b0);
        send_byte(8'h9F, 1);
        expect_byte(8'hE0, 4'b0010, "R1");
        recv_bytes(1, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(lane_oe == 4'b0000, "R1", "oe after reset asserted", lane_oe, 0);
        oe0 = oe_cnt;
        pad(8);
        chk(oe_cnt == oe0, "R1", "driven during reset", oe_cnt - oe0, 0);
        rst_n = 1'b1;
        pad(16);
        chk(oe_cnt == oe0, "R2", "driven after reset without new select", oe_cnt - oe0, 0);
        deselect(1'b0);
        select(1'b0);
        send_byte(8'h9F, 1);
        expect_byte(8'hE0, 4'b0010, "R2");
        recv_bytes(1, 1);
        deselect(1'b0);

        wait (rx_q.size() == 0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "expected bytes left over", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule